// File: doc/BRIEF.md
# Attribute Load Return Selector

This block forms the returned words of an attribute load. A request gives a signed byte address, a size code (one to four 32-bit words), a destination register index and a path select. The path select picks either the input side, which holds what the previous stage produced, or the output side, which holds what the current stage produced. The request also carries per-word map bits for the neighbouring stages and per-word write-status bits.

For each word of the load, the block builds a buffer-map bit from the maps. Together with the write status, that bit decides what comes back:

- the stored stage output;
- leftover buffer contents;
- an address-dependent default constant.

The block holds a two-bank attribute buffer (input side and output side), which is filled through a write port. The address is aligned by dropping low bits according to the size, and the destination register index is aligned in the same way.

Results are registered. They appear one cycle after the request, qualified by a valid output, with a 2-bit source tag for each word.

Top module: `attr_ret_sel`

## Requirements
- R1: On the input path (req_io=0) the map bit of word w is cur_imap[w] AND prev_omap[w]; with map bit 1 and wr_status[w]=1 the lane returns input-bank word w with tag 2'b00 (stage output).
- R2: On the output path (req_io=1) the map bit is cur_omap[w] AND (next_imap[w] OR cur_streq[w]); with map bit 1 and wr_status[w]=1 the lane returns output-bank word w with tag 2'b00.
- R3: A map bit of 0 returns the default value with tag 2'b10, whatever wr_status is.
- R4: A map bit of 1 with wr_status 0 returns the buffer word with tag 2'b01 on the input path (leftover or hardware-generated) and tag 2'b11 on the output path (leftover).
- R5: The default value is 32'h3F800000 when bits 3:2 of the word's byte address are 2'b11, and 32'h00000000 otherwise.
- R6: A word whose byte address is negative or at least 1024 returns 32'h00000000 with tag 2'b10, whatever the map bits are.
- R7: Size code 0,1,2,3 enables 1,2,3,4 consecutive words (rsp_lane_en = 0001, 0011, 0111, 1111); lane l uses byte address base+4*l; disabled lanes return 0 with tag 2'b10.
- R8: The base address drops 2 low bits for size 0, 3 low bits for size 1 and 4 low bits for sizes 2 and 3.
- R9: rsp_rd equals req_rd with bit 0 cleared for size 1, bits 1:0 cleared for sizes 2 and 3, and unchanged for size 0.
- R10: rsp_valid is 1 exactly in the cycle after a cycle with req_valid=1, and the results appear with that same one-cycle latency.
- R11: After reset rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Buffer write enable |
| wr_bank | input | 1 | Buffer bank to write (0 input, 1 output) |
| wr_idx | input | 8 | Buffer word index to write |
| wr_data | input | 32 | Buffer write data |
| req_valid | input | 1 | Load request strobe |
| req_io | input | 1 | Path select (0 input, 1 output) |
| req_addr | input | 12 | Signed byte address |
| req_size | input | 2 | Word count minus one |
| req_rd | input | 8 | Destination register index |
| cur_imap | input | 256 | Current stage input map, one bit per word |
| cur_omap | input | 256 | Current stage output map |
| prev_omap | input | 256 | Previous stage output map |
| next_imap | input | 256 | Next stage input map |
| cur_streq | input | 256 | Current stage store-request bits |
| wr_status | input | 256 | Write status of the selected path, one bit per word |
| rsp_valid | output | 1 | Result valid |
| rsp_rd | output | 8 | Aligned destination register index |
| rsp_lane_en | output | 4 | Enabled lanes |
| rsp_data | output | 128 | Lane words, lane l at bits 32*l+31:32*l |
| rsp_tag | output | 8 | Lane source tags, lane l at bits 2*l+1:2*l |

## Verification
Each map term is toggled on its own on both paths, so that the AND and OR structure of the input and output map rules is told apart from a plain copy of one map. Write status is swept with the map set and with it clear, which separates stage-output, leftover and default outcomes. The leftover tags tell the two paths apart. Vector loads use unaligned addresses with mixed map bits across lanes, which exposes lane order, base alignment, the w-component default and the register-index masking for each size code. Addresses just inside and beyond the 1024-byte limit and a negative address show that the range check overrides both the map and the default constant.

// File: rtl/attr_ret_pkg.sv
package attr_ret_pkg;
    typedef enum logic [1:0] {
        SRC_STAGE   = 2'b00,
        SRC_HWLEFT  = 2'b01,
        SRC_DEFAULT = 2'b10,
        SRC_GARBAGE = 2'b11
    } src_tag_e;

    localparam logic [31:0] ONE_FLOAT = 32'h3F80_0000;
endpackage

// File: rtl/attr_buffer.sv
module attr_buffer #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 256,
    parameter int LANES     = 4,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic                    wr_bank,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    rd_bank,
    input  logic [LANES*IDX_W-1:0]  rd_idx,
    output logic [LANES*DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [2][NUM_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_bank][wr_idx] <= wr_data;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        assign rd_data[l*DATA_W +: DATA_W] = mem_q[rd_bank][rd_idx[l*IDX_W +: IDX_W]];
    end
endmodule

// File: rtl/attr_lane_sel.sv
module attr_lane_sel
    import attr_ret_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              lane_on,
    input  logic              io_out,
    input  logic              in_range,
    input  logic              w_slot,
    input  logic              imap_cur,
    input  logic              omap_prev,
    input  logic              omap_cur,
    input  logic              imap_next,
    input  logic              streq,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] buf_word,
    output logic [DATA_W-1:0] word_d,
    output src_tag_e          tag_d
);
    logic map_bit;
    logic [DATA_W-1:0] dflt;

    always_comb begin
        map_bit = io_out ? (omap_cur & (imap_next | streq)) : (imap_cur & omap_prev);
        dflt    = w_slot ? DATA_W'(ONE_FLOAT) : '0;
        if (!lane_on || !in_range) begin
            word_d = '0;
            tag_d  = SRC_DEFAULT;
        end else if (!map_bit) begin
            word_d = dflt;
            tag_d  = SRC_DEFAULT;
        end else if (wr_stat) begin
            word_d = buf_word;
            tag_d  = SRC_STAGE;
        end else begin
            word_d = buf_word;
            tag_d  = io_out ? SRC_GARBAGE : SRC_HWLEFT;
        end
    end

    always_comb begin
        // R5
        dflt_const_chk: assert (tag_d != SRC_DEFAULT || word_d == '0 || word_d == DATA_W'(ONE_FLOAT));
        // R4
        left_path_chk: assert (!(tag_d == SRC_HWLEFT && io_out) && !(tag_d == SRC_GARBAGE && !io_out));
    end
endmodule

// File: rtl/attr_ret_sel.sv
module attr_ret_sel
    import attr_ret_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 256,
    parameter int ADDR_W    = 12,
    parameter int REG_W     = 8,
    localparam int LANES    = 4,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int LIMIT_B  = NUM_WORDS * 4,
    localparam int EXT_W    = ADDR_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_bank,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    req_valid,
    input  logic                    req_io,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic [REG_W-1:0]        req_rd,
    input  logic [NUM_WORDS-1:0]    cur_imap,
    input  logic [NUM_WORDS-1:0]    cur_omap,
    input  logic [NUM_WORDS-1:0]    prev_omap,
    input  logic [NUM_WORDS-1:0]    next_imap,
    input  logic [NUM_WORDS-1:0]    cur_streq,
    input  logic [NUM_WORDS-1:0]    wr_status,
    output logic                    rsp_valid,
    output logic [REG_W-1:0]        rsp_rd,
    output logic [LANES-1:0]        rsp_lane_en,
    output logic [LANES*DATA_W-1:0] rsp_data,
    output logic [LANES*2-1:0]      rsp_tag
);
    typedef struct packed {
        logic                    valid;
        logic [REG_W-1:0]        rd;
        logic [LANES-1:0]        lane_en;
        logic [LANES*DATA_W-1:0] data;
        logic [LANES*2-1:0]      tag;
    } state_t;

    state_t s_d, s_q;

    logic [EXT_W-1:0]        base_d;
    logic [EXT_W-1:0]        low_mask;
    logic [REG_W-1:0]        rd_aligned_d;
    logic [LANES*IDX_W-1:0]  rd_idx;
    logic [LANES*DATA_W-1:0] buf_words;
    logic [LANES*DATA_W-1:0] lane_word_d;
    logic [LANES*2-1:0]      lane_tag_d;
    logic [LANES-1:0]        lane_on_d;

    always_comb begin
        unique case (req_size)
            2'd0:    low_mask = EXT_W'(3);
            2'd1:    low_mask = EXT_W'(7);
            default: low_mask = EXT_W'(15);
        endcase
        base_d = {req_addr[ADDR_W-1], req_addr} & ~low_mask;
        unique case (req_size)
            2'd0:    rd_aligned_d = req_rd;
            2'd1:    rd_aligned_d = {req_rd[REG_W-1:1], 1'b0};
            default: rd_aligned_d = {req_rd[REG_W-1:2], 2'b00};
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [EXT_W-1:0] wa;
        logic             in_rng;
        logic [IDX_W-1:0] idx;
        src_tag_e         tag_l;

        assign wa     = base_d + EXT_W'(4 * l);
        assign in_rng = !wa[EXT_W-1] && (wa[ADDR_W-1:0] < ADDR_W'(LIMIT_B));
        assign idx    = wa[IDX_W+1:2];
        assign rd_idx[l*IDX_W +: IDX_W] = idx;
        assign lane_on_d[l] = (2'(l) <= req_size);

        attr_lane_sel #(.DATA_W(DATA_W)) u_sel (
            .lane_on   (lane_on_d[l]),
            .io_out    (req_io),
            .in_range  (in_rng),
            .w_slot    (wa[3] & wa[2]),
            .imap_cur  (cur_imap[idx]),
            .omap_prev (prev_omap[idx]),
            .omap_cur  (cur_omap[idx]),
            .imap_next (next_imap[idx]),
            .streq     (cur_streq[idx]),
            .wr_stat   (wr_status[idx]),
            .buf_word  (buf_words[l*DATA_W +: DATA_W]),
            .word_d    (lane_word_d[l*DATA_W +: DATA_W]),
            .tag_d     (tag_l)
        );
        assign lane_tag_d[l*2 +: 2] = tag_l;

        // R6
        oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !in_rng) |=> (rsp_data[l*DATA_W +: DATA_W] == '0
                                        && rsp_tag[l*2 +: 2] == SRC_DEFAULT));
    end

    attr_buffer #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .LANES(LANES)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_bank (req_io),
        .rd_idx  (rd_idx),
        .rd_data (buf_words)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = req_valid;
        if (req_valid) begin
            s_d.rd      = rd_aligned_d;
            s_d.lane_en = lane_on_d;
            s_d.data    = lane_word_d;
            s_d.tag     = lane_tag_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid   = s_q.valid;
    assign rsp_rd      = s_q.rd;
    assign rsp_lane_en = s_q.lane_en;
    assign rsp_data    = s_q.data;
    assign rsp_tag     = s_q.tag;

    // R10
    lat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R10
    lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R7
    lane_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_lane_en[0] && (!rsp_lane_en[3] || rsp_lane_en[2])
                       && (!rsp_lane_en[2] || rsp_lane_en[1])));
    // R9
    rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_lane_en[1]) |-> !rsp_rd[0]);
    // R9
    rd_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_lane_en[2]) |-> (rsp_rd[1:0] == 2'b00));
endmodule

// File: tb/sim_attr_ret_sel.sv
module sim_attr_ret_sel;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_bank = 1'b0;
    logic [7:0]   wr_idx = '0;
    logic [31:0]  wr_data = '0;
    logic         req_valid = 1'b0;
    logic         req_io = 1'b0;
    logic [11:0]  req_addr = '0;
    logic [1:0]   req_size = '0;
    logic [7:0]   req_rd = '0;
    logic [255:0] cur_imap = '0, cur_omap = '0, prev_omap = '0;
    logic [255:0] next_imap = '0, cur_streq = '0, wr_status = '0;
    logic         rsp_valid;
    logic [7:0]   rsp_rd;
    logic [3:0]   rsp_lane_en;
    logic [127:0] rsp_data;
    logic [7:0]   rsp_tag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    attr_ret_sel u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
        .wr_data(wr_data), .req_valid(req_valid), .req_io(req_io), .req_addr(req_addr),
        .req_size(req_size), .req_rd(req_rd), .cur_imap(cur_imap), .cur_omap(cur_omap),
        .prev_omap(prev_omap), .next_imap(next_imap), .cur_streq(cur_streq),
        .wr_status(wr_status), .rsp_valid(rsp_valid), .rsp_rd(rsp_rd),
        .rsp_lane_en(rsp_lane_en), .rsp_data(rsp_data), .rsp_tag(rsp_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_lane(string req, int l, logic [31:0] d, logic [1:0] t);
        chk(req, rsp_data[32*l +: 32], d);
        chk(req, {30'd0, rsp_tag[2*l +: 2]}, {30'd0, t});
    endtask

    task automatic clear_maps();
        cur_imap = '0; cur_omap = '0; prev_omap = '0;
        next_imap = '0; cur_streq = '0; wr_status = '0;
    endtask

    task automatic issue(logic io, logic [11:0] a, logic [1:0] sz, logic [7:0] rd);
        @(negedge clk);
        req_io = io; req_addr = a; req_size = sz; req_rd = rd; req_valid = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic fill_buffer();
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 256; i++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_bank = b[0]; wr_idx = i[7:0];
                wr_data = (b == 0) ? (32'hA000_0000 + i) : (32'hB000_0000 + i);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_input_path();
        clear_maps();
        cur_imap[4] = 1'b1; prev_omap[4] = 1'b1; wr_status[4] = 1'b1;
        issue(1'b0, 12'd16, 2'd0, 8'd3);
        chk("R10", {31'd0, rsp_valid}, 32'd1);
        chk_lane("R1", 0, 32'hA000_0004, 2'b00);
        chk("R7", {28'd0, rsp_lane_en}, 32'h1);
        prev_omap[4] = 1'b0;
        issue(1'b0, 12'd16, 2'd0, 8'd3);
        chk_lane("R1", 0, 32'h0, 2'b10);
        prev_omap[4] = 1'b1; cur_imap[4] = 1'b0;
        issue(1'b0, 12'd16, 2'd0, 8'd3);
        chk_lane("R1", 0, 32'h0, 2'b10);
    endtask

    task automatic t_output_path();
        clear_maps();
        cur_omap[5] = 1'b1; cur_streq[5] = 1'b1; wr_status[5] = 1'b1;
        issue(1'b1, 12'd20, 2'd0, 8'd0);
        chk_lane("R2", 0, 32'hB000_0005, 2'b00);
        cur_streq[5] = 1'b0;
        issue(1'b1, 12'd20, 2'd0, 8'd0);
        chk_lane("R2", 0, 32'h0, 2'b10);
        next_imap[5] = 1'b1;
        issue(1'b1, 12'd20, 2'd0, 8'd0);
        chk_lane("R2", 0, 32'hB000_0005, 2'b00);
        cur_omap[5] = 1'b0;
        issue(1'b1, 12'd20, 2'd0, 8'd0);
        chk_lane("R2", 0, 32'h0, 2'b10);
    endtask

    task automatic t_write_status();
        clear_maps();
        cur_imap[5] = 1'b1; prev_omap[5] = 1'b1; cur_omap[5] = 1'b1; next_imap[5] = 1'b1;
        issue(1'b0, 12'd20, 2'd0, 8'd0);
        chk_lane("R4", 0, 32'hA000_0005, 2'b01);
        issue(1'b1, 12'd20, 2'd0, 8'd0);
        chk_lane("R4", 0, 32'hB000_0005, 2'b11);
        cur_imap[5] = 1'b0; wr_status[5] = 1'b1;
        issue(1'b0, 12'd20, 2'd0, 8'd0);
        chk_lane("R3", 0, 32'h0, 2'b10);
    endtask

    task automatic t_vector();
        clear_maps();
        cur_imap[4] = 1'b1; prev_omap[4] = 1'b1; wr_status[4] = 1'b1;
        cur_imap[6] = 1'b1; prev_omap[6] = 1'b1;
        wr_status[5] = 1'b1; wr_status[7] = 1'b1;
        issue(1'b0, 12'd28, 2'd3, 8'h0B);
        chk("R7", {28'd0, rsp_lane_en}, 32'hF);
        chk("R9", {24'd0, rsp_rd}, 32'h08);
        chk_lane("R8", 0, 32'hA000_0004, 2'b00);
        chk_lane("R3", 1, 32'h0, 2'b10);
        chk_lane("R4", 2, 32'hA000_0006, 2'b01);
        chk_lane("R5", 3, 32'h3F80_0000, 2'b10);
    endtask

    task automatic t_sizes();
        clear_maps();
        issue(1'b1, 12'd44, 2'd1, 8'h07);
        chk("R7", {28'd0, rsp_lane_en}, 32'h3);
        chk("R9", {24'd0, rsp_rd}, 32'h06);
        chk_lane("R5", 0, 32'h0, 2'b10);
        chk_lane("R5", 1, 32'h3F80_0000, 2'b10);
        chk_lane("R7", 2, 32'h0, 2'b10);
        cur_imap = '1; prev_omap = '1; wr_status = '1;
        issue(1'b0, 12'h01F, 2'd2, 8'h07);
        chk("R7", {28'd0, rsp_lane_en}, 32'h7);
        chk("R9", {24'd0, rsp_rd}, 32'h04);
        chk_lane("R8", 0, 32'hA000_0004, 2'b00);
        chk_lane("R8", 2, 32'hA000_0006, 2'b00);
        chk_lane("R7", 3, 32'h0, 2'b10);
        issue(1'b0, 12'd23, 2'd0, 8'h07);
        chk("R9", {24'd0, rsp_rd}, 32'h07);
        chk_lane("R8", 0, 32'hA000_0005, 2'b00);
    endtask

    task automatic t_range();
        clear_maps();
        cur_imap = '1; prev_omap = '1; wr_status = '1;
        issue(1'b0, 12'd1020, 2'd0, 8'd0);
        chk_lane("R6", 0, 32'hA000_00FF, 2'b00);
        issue(1'b0, 12'd1036, 2'd0, 8'd0);
        chk_lane("R6", 0, 32'h0, 2'b10);
        issue(1'b0, 12'hFFC, 2'd0, 8'd0);
        chk_lane("R6", 0, 32'h0, 2'b10);
        cur_imap = '0;
        issue(1'b0, 12'd1020, 2'd0, 8'd0);
        chk_lane("R5", 0, 32'h3F80_0000, 2'b10);
    endtask

    task automatic t_latency();
        issue(1'b0, 12'd0, 2'd0, 8'd0);
        @(posedge clk);
        #1;
        chk("R10", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R11", {31'd0, rsp_valid}, 32'd0);
        fill_buffer();
        t_input_path();
        t_output_path();
        t_write_status();
        t_vector();
        t_sizes();
        t_range();
        t_latency();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule